// File: doc/BRIEF.md
# Multi-Channel Prescaled Timer Counter

This block is a bank of independent up-counting timer channels, eight by default, each with a 16-bit counter. A simple synchronous register bus controls the bank. Each channel picks its count source from three clock enables that arrive from the same clock domain: a peripheral tick, a real-time tick and an external tick. The chosen source passes through a power-of-four prescaler. The counter then advances, and it returns to zero after it reaches the channel's compare value. At that point the channel sends a one-cycle flag pulse to an interrupt controller.

Software starts and stops channels through write-one-to-set and write-one-to-clear registers, so two agents can change different channels without read-modify-write races. A separate pair of set/clear registers stops the clock to a channel. The control register of a channel accepts writes only while that channel's clock runs. Software can read and write the counter and compare registers at any time, so it can clear a counter before a countdown or preload it with a value taken from another channel.

Top module: `tmr_bank`

## Requirements
- R1: After reset, the enable status (word address 0) reads 0 and the stop status (address 3) reads all ones. Every channel control register reads 0, every compare register reads 0xFFFF and every counter reads 0.
- R2: Writing to address 1 sets the enable bit of each channel c whose write-data bit c is 1. Writing to address 2 clears those enable bits. Zero bits leave channels unchanged, and address 0 reads the enables back.
- R3: Addresses 4 (set) and 5 (clear) drive the stop bits in the same way, and address 3 reads them back. A stop bit of 1 means the channel's clock is stopped.
- R4: Channel c's control register is at word address 8+4c. While channel c's stop bit is 1, writes to it are ignored and the read value stays unchanged.
- R5: Control bits [2:0] select the source one-hot: bit 0 selects the peripheral tick, bit 1 the real-time tick and bit 2 the external tick. The counter sees source cycles only where a selected enable is high; several set bits are ORed, and no set bit means the counter never advances.
- R6: Control bits [5:3] hold a prescale value n. The counter advances once per 4^n selected source cycles, counted from the moment the channel is enabled. Values 6 and 7 behave as 5 (ratio 1024).
- R7: A counter holds its value while its channel is disabled or stopped, whatever the source inputs do.
- R8: The compare register (8+4c+1) and the counter register (8+4c+2) accept writes at any time and read back the value written.
- R9: When a count step finds the counter equal to the compare value, the counter goes to 0 and the channel's flag output is high for the following cycle. Otherwise the counter increments.
- R10: With compare 0xFFFF, the counter runs free. It wraps from 0xFFFF to 0 and raises a flag at the wrap.
- R11: Channels are independent: channels enabled together with different sources, prescalers and compare values each count only their own selected ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Word address for write and read |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for addr |
| srcPeriph | input | 1 | Peripheral clock enable |
| srcRtc | input | 1 | Real-time clock enable |
| srcExt | input | 1 | External clock enable |
| chFlag | output | 8 | Per-channel compare-match pulse |

## Verification
The hardest state to reach from the ports is a long run of prescaled counting whose result depends on the exact number of source pulses a channel saw. This includes prescale values 5 to 7, compare wrap in the middle of a run, and two channels sharing the source inputs. The bench drives random source-enable patterns on the three tick inputs and counts the cycles on which each channel's selected sources were high. It then derives the expected counter value and flag count from that pulse count, the prescale ratio and the compare value. Directed runs of several thousand cycles cover the 1024 ratio and the free-running wrap from a preloaded 0xFFFE.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // source select bit positions inside a channel control word
  localparam int SRC_N      = 3;
  localparam int SRC_PERIPH = 0;
  localparam int SRC_RTC    = 1;
  localparam int SRC_EXT    = 2;
  // prescale field width and control width
  localparam int PRE_FW = 3;
  localparam int CTRL_W = SRC_N + PRE_FW;

  // global word addresses
  localparam int REG_ENA       = 0;
  localparam int REG_ENA_SET   = 1;
  localparam int REG_ENA_CLR   = 2;
  localparam int REG_STOP      = 3;
  localparam int REG_STOP_SET  = 4;
  localparam int REG_STOP_CLR  = 5;
  // per-channel window
  localparam int CH_BASE   = 8;
  localparam int CH_STRIDE = 4;
  localparam logic [1:0] FLD_CTRL = 2'd0;
  localparam logic [1:0] FLD_CMP  = 2'd1;
  localparam logic [1:0] FLD_CNT  = 2'd2;

  // write strobes from the register control to one channel datapath
  typedef struct packed {
    logic ctrlWr;
    logic cmpWr;
    logic cntWr;
  } chStrobe_t;
endpackage

// File: rtl/tmr_regctl.sv
`timescale 1ns/1ps
module tmr_regctl import tmr_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_CH-1:0]                 maskData,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]     chCtrl,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      chCmp,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      chCnt,
  output chStrobe_t [NUM_CH-1:0]            strobe,
  output logic [NUM_CH-1:0]                 enMask,
  output logic [NUM_CH-1:0]                 stopMask,
  output logic [CNT_W-1:0]                  rdData
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SEL_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] A_ENA      = ADDR_W'(REG_ENA);
  localparam logic [ADDR_W-1:0] A_ENA_SET  = ADDR_W'(REG_ENA_SET);
  localparam logic [ADDR_W-1:0] A_ENA_CLR  = ADDR_W'(REG_ENA_CLR);
  localparam logic [ADDR_W-1:0] A_STOP     = ADDR_W'(REG_STOP);
  localparam logic [ADDR_W-1:0] A_STOP_SET = ADDR_W'(REG_STOP_SET);
  localparam logic [ADDR_W-1:0] A_STOP_CLR = ADDR_W'(REG_STOP_CLR);
  localparam logic [ADDR_W-1:0] A_CH_BASE  = ADDR_W'(CH_BASE);

  logic [ADDR_W-1:0] chOff;
  logic [SEL_W-1:0]  chSel;
  logic [IDX_W-1:0]  chIdx;
  logic [1:0]        fld;
  logic              inChSpace;

  assign chOff     = addr - A_CH_BASE;
  assign chSel     = chOff[ADDR_W-1:2];
  assign chIdx     = chSel[IDX_W-1:0];
  assign fld       = chOff[1:0];
  assign inChSpace = (addr >= A_CH_BASE) && (chSel < SEL_W'(NUM_CH));

  // write strobes, control word gated by the channel's stop bit
  for (genvar c = 0; c < NUM_CH; c++) begin : g_str
    logic hit;
    assign hit = wrEn && inChSpace && (chSel == SEL_W'(c));
    assign strobe[c].ctrlWr = hit && (fld == FLD_CTRL) && !stopMask[c];
    assign strobe[c].cmpWr  = hit && (fld == FLD_CMP);
    assign strobe[c].cntWr  = hit && (fld == FLD_CNT);
  end

  // atomic set/clear registers for enable and stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask   <= '0;
      stopMask <= '1;
    end else if (wrEn) begin
      case (addr)
        A_ENA_SET:  enMask   <= enMask | maskData;
        A_ENA_CLR:  enMask   <= enMask & ~maskData;
        A_STOP_SET: stopMask <= stopMask | maskData;
        A_STOP_CLR: stopMask <= stopMask & ~maskData;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == A_ENA)       rdData = CNT_W'(enMask);
    else if (addr == A_STOP) rdData = CNT_W'(stopMask);
    else if (inChSpace) begin
      case (fld)
        FLD_CTRL: rdData = CNT_W'(chCtrl[chIdx]);
        FLD_CMP:  rdData = chCmp[chIdx];
        FLD_CNT:  rdData = chCnt[chIdx];
        default:  rdData = '0;
      endcase
    end
  end

  // R2: set and clear act only on the written one bits
  a_r2_ena_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_ENA_SET) |=> ((enMask & $past(maskData)) == $past(maskData)));
  a_r2_ena_clr: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_ENA_CLR) |=> ((enMask & $past(maskData)) == '0));
  a_r2_ena_keep: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (addr == A_ENA_SET || addr == A_ENA_CLR)) |=> $stable(enMask));
  // R3: same for stop
  a_r3_stop_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_STOP_SET) |=> ((stopMask & $past(maskData)) == $past(maskData)));
  a_r3_stop_clr: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_STOP_CLR) |=> ((stopMask & $past(maskData)) == '0));
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel import tmr_pkg::*; #(
  parameter int CNT_W   = 16,
  parameter int MAX_PRE = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  chStrobe_t          strobe,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               chEn,
  input  logic               chStop,
  input  logic [SRC_N-1:0]   srcEn,
  output logic [CTRL_W-1:0]  ctrl,
  output logic [CNT_W-1:0]   cmp,
  output logic [CNT_W-1:0]   cnt,
  output logic               flag
);
  localparam int PRE_W = 2 * MAX_PRE;

  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  cmpReg, cntReg;
  logic [PRE_W-1:0]  preCnt, preMask;
  logic [SRC_N-1:0]  srcSel;
  logic [PRE_FW-1:0] preSel, effPre;
  logic              run, srcHit, preTerm, tick, match;

  assign srcSel  = ctrlReg[SRC_N-1:0];
  assign preSel  = ctrlReg[CTRL_W-1:SRC_N];
  assign effPre  = (preSel > PRE_FW'(MAX_PRE)) ? PRE_FW'(MAX_PRE) : preSel;
  assign preMask = ~({PRE_W{1'b1}} << {effPre, 1'b0});
  assign run     = chEn && !chStop;
  assign srcHit  = |(srcSel & srcEn);
  assign preTerm = (preCnt == preMask);
  assign tick    = run && srcHit && preTerm;
  assign match   = (cntReg == cmpReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      cmpReg  <= '1;
    end else begin
      if (strobe.ctrlWr) ctrlReg <= wrData[CTRL_W-1:0];
      if (strobe.cmpWr)  cmpReg  <= wrData;
    end
  end

  // prescaler restarts whenever the channel is disabled or reconfigured
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        preCnt <= '0;
    else if (!chEn || strobe.ctrlWr)  preCnt <= '0;
    else if (run && srcHit)           preCnt <= preTerm ? '0 : preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
      flag   <= 1'b0;
    end else begin
      flag <= tick && match && !strobe.cntWr;
      if (strobe.cntWr)  cntReg <= wrData;
      else if (tick)     cntReg <= match ? '0 : cntReg + CNT_W'(1);
    end
  end

  assign ctrl = ctrlReg;
  assign cmp  = cmpReg;
  assign cnt  = cntReg;

  // R4: control word frozen while the clock is stopped
  a_r4_ctrl_locked: assert property (@(posedge clk) disable iff (!rstN)
    $past(chStop) |-> $stable(ctrlReg));
  // R7: no counting while disabled or stopped
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((!$past(chEn) || $past(chStop)) && !$past(strobe.cntWr)) |-> $stable(cntReg));
  a_r7_flag_run: assert property (@(posedge clk) disable iff (!rstN)
    flag |-> $past(chEn && !chStop));
  // R5: a flag needs a selected source pulse
  a_r5_flag_src: assert property (@(posedge clk) disable iff (!rstN)
    flag |-> $past(|(srcEn & srcSel)));
  // R9: flag follows a compare match and leaves the counter at zero
  a_r9_flag_match: assert property (@(posedge clk) disable iff (!rstN)
    flag |-> ($past(cntReg) == $past(cmpReg)));
  a_r9_flag_zero: assert property (@(posedge clk) disable iff (!rstN)
    flag |-> (cntReg == '0));
endmodule

// File: rtl/tmr_datapath.sv
`timescale 1ns/1ps
module tmr_datapath import tmr_pkg::*; #(
  parameter int NUM_CH  = 8,
  parameter int CNT_W   = 16,
  parameter int MAX_PRE = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  chStrobe_t [NUM_CH-1:0]         strobe,
  input  logic [CNT_W-1:0]               wrData,
  input  logic [NUM_CH-1:0]              enMask,
  input  logic [NUM_CH-1:0]              stopMask,
  input  logic [SRC_N-1:0]               srcEn,
  output logic [NUM_CH-1:0][CTRL_W-1:0]  chCtrl,
  output logic [NUM_CH-1:0][CNT_W-1:0]   chCmp,
  output logic [NUM_CH-1:0][CNT_W-1:0]   chCnt,
  output logic [NUM_CH-1:0]              chFlag
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W), .MAX_PRE(MAX_PRE)) u_ch (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe[c]),
      .wrData (wrData),
      .chEn   (enMask[c]),
      .chStop (stopMask[c]),
      .srcEn  (srcEn),
      .ctrl   (chCtrl[c]),
      .cmp    (chCmp[c]),
      .cnt    (chCnt[c]),
      .flag   (chFlag[c])
    );
  end
endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank import tmr_pkg::*; #(
  parameter int NUM_CH  = 8,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 6,
  parameter int MAX_PRE = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wrData,
  output logic [CNT_W-1:0]   rdData,
  input  logic               srcPeriph,
  input  logic               srcRtc,
  input  logic               srcExt,
  output logic [NUM_CH-1:0]  chFlag
);
  chStrobe_t [NUM_CH-1:0]           strobe;
  logic [NUM_CH-1:0]                enMask, stopMask;
  logic [NUM_CH-1:0][CTRL_W-1:0]    chCtrl;
  logic [NUM_CH-1:0][CNT_W-1:0]     chCmp, chCnt;
  logic [SRC_N-1:0]                 srcEn;

  always_comb begin
    srcEn             = '0;
    srcEn[SRC_PERIPH] = srcPeriph;
    srcEn[SRC_RTC]    = srcRtc;
    srcEn[SRC_EXT]    = srcExt;
  end

  tmr_regctl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .maskData (wrData[NUM_CH-1:0]),
    .chCtrl   (chCtrl),
    .chCmp    (chCmp),
    .chCnt    (chCnt),
    .strobe   (strobe),
    .enMask   (enMask),
    .stopMask (stopMask),
    .rdData   (rdData)
  );

  tmr_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .MAX_PRE(MAX_PRE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .enMask   (enMask),
    .stopMask (stopMask),
    .srcEn    (srcEn),
    .chCtrl   (chCtrl),
    .chCmp    (chCmp),
    .chCnt    (chCnt),
    .chFlag   (chFlag)
  );
endmodule

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;
  localparam int NCH = 8;
  localparam int A_ENA = 0, A_ENA_SET = 1, A_ENA_CLR = 2;
  localparam int A_STOP = 3, A_STOP_SET = 4, A_STOP_CLR = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        srcPeriph = 1'b0, srcRtc = 1'b0, srcExt = 1'b0;
  logic [NCH-1:0] chFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int flagCnt [NCH];

  // per-run configuration
  int tSrc [NCH];
  int tPre [NCH];
  int tCmp [NCH];
  int tStart [NCH];

  always #10 clk = ~clk;

  tmr_bank u_tmr_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .srcPeriph(srcPeriph), .srcRtc(srcRtc), .srcExt(srcExt),
    .chFlag(chFlag)
  );

  initial for (int i = 0; i < NCH; i++) flagCnt[i] = 0;
  always @(negedge clk)
    for (int i = 0; i < NCH; i++) if (chFlag[i]) flagCnt[i]++;

  function automatic int chAddr(input int c, input int f);
    return 8 + 4 * c + f;
  endfunction

  // expected counter and flag count after a number of count steps
  function automatic void model(input int start, input int steps, input int cmpV,
                                output int cntV, output int flags);
    int cur = start;
    flags = 0;
    for (int i = 0; i < steps; i++) begin
      if (cur == cmpV) begin cur = 0; flags++; end
      else cur = (cur + 1) & 16'hFFFF;
    end
    cntV = cur;
  endfunction

  function automatic int ratioShift(input int pre);
    return 2 * ((pre > 5) ? 5 : pre);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 6'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input int a, output int d);
    @(negedge clk);
    addr = 6'(a);
    #1 d = int'(rdData);
  endtask

  // configure the channels in chMask, run them together, then check
  task automatic runGroup(input int chMask, input int cycles, input int density);
    int pulses [NCH];
    int base [NCH];
    int rd, expCnt, expFlags;
    for (int c = 0; c < NCH; c++) begin
      pulses[c] = 0;
      if (chMask[c]) begin
        busWrite(A_STOP_CLR, 1 << c);
        busWrite(chAddr(c, 0), (tPre[c] << 3) | tSrc[c]);
        busWrite(chAddr(c, 1), tCmp[c]);
        busWrite(chAddr(c, 2), tStart[c]);
      end
    end
    @(negedge clk);
    for (int c = 0; c < NCH; c++) base[c] = flagCnt[c];
    busWrite(A_ENA_SET, chMask);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      srcPeriph = (($urandom % 100) < density);
      srcRtc    = (($urandom % 100) < density);
      srcExt    = (($urandom % 100) < density);
      for (int c = 0; c < NCH; c++)
        if (chMask[c] && ((tSrc[c] & {srcExt, srcRtc, srcPeriph}) != 0)) pulses[c]++;
    end
    @(negedge clk);
    srcPeriph = 1'b0; srcRtc = 1'b0; srcExt = 1'b0;
    busWrite(A_ENA_CLR, chMask);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (chMask[c]) begin
        model(tStart[c], pulses[c] >> ratioShift(tPre[c]), tCmp[c], expCnt, expFlags);
        busRead(chAddr(c, 2), rd);
        check($sformatf("R6/R9 ch%0d count", c), rd, expCnt);
        check($sformatf("R9 ch%0d flags", c), flagCnt[c] - base[c], expFlags);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rd, seed;
    seed = $urandom(32'd7341);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(A_ENA, rd);           check("R1 enable", rd, 0);
    busRead(A_STOP, rd);          check("R1 stop", rd, 16'hFF);
    busRead(chAddr(0, 0), rd);    check("R1 ctrl", rd, 0);
    busRead(chAddr(0, 1), rd);    check("R1 cmp", rd, 16'hFFFF);
    busRead(chAddr(7, 1), rd);    check("R1 cmp ch7", rd, 16'hFFFF);
    busRead(chAddr(3, 2), rd);    check("R1 cnt", rd, 0);

    // R4 control write ignored while stopped
    busWrite(chAddr(2, 0), 16'h2A);
    busRead(chAddr(2, 0), rd);    check("R4 stopped write", rd, 0);
    busWrite(A_STOP_CLR, 1 << 2);
    busWrite(chAddr(2, 0), 16'h2A);
    busRead(chAddr(2, 0), rd);    check("R4 running write", rd, 16'h2A);
    busWrite(A_STOP_SET, 1 << 2);
    busWrite(chAddr(2, 0), 16'h11);
    busRead(chAddr(2, 0), rd);    check("R4 restopped write", rd, 16'h2A);

    // R2 enable set/clear
    busWrite(A_ENA_SET, 16'h05); busRead(A_ENA, rd); check("R2 set", rd, 16'h05);
    busWrite(A_ENA_SET, 16'h02); busRead(A_ENA, rd); check("R2 set more", rd, 16'h07);
    busWrite(A_ENA_CLR, 16'h04); busRead(A_ENA, rd); check("R2 clear", rd, 16'h03);
    busWrite(A_ENA_CLR, 16'h00); busRead(A_ENA, rd); check("R2 zero clear", rd, 16'h03);
    busWrite(A_ENA_CLR, 16'hFF); busRead(A_ENA, rd); check("R2 clear all", rd, 0);

    // R3 stop set/clear
    busWrite(A_STOP_CLR, 16'h0F); busRead(A_STOP, rd); check("R3 clear", rd, 16'hF0);
    busWrite(A_STOP_SET, 16'h01); busRead(A_STOP, rd); check("R3 set", rd, 16'hF1);
    busWrite(A_STOP_SET, 16'h00); busRead(A_STOP, rd); check("R3 zero set", rd, 16'hF1);
    busWrite(A_STOP_SET, 16'hFF); busRead(A_STOP, rd); check("R3 set all", rd, 16'hFF);

    // R7 stopped-but-enabled, then running-but-disabled: no counting
    busWrite(A_STOP_CLR, 1 << 4);
    busWrite(chAddr(4, 0), 16'h01);
    busWrite(A_STOP_SET, 1 << 4);
    busWrite(A_ENA_SET, 1 << 4);
    @(negedge clk); srcPeriph = 1'b1; srcRtc = 1'b1; srcExt = 1'b1;
    repeat (20) @(negedge clk);
    srcPeriph = 1'b0; srcRtc = 1'b0; srcExt = 1'b0;
    busRead(chAddr(4, 2), rd);    check("R7 stopped hold", rd, 0);
    busWrite(A_ENA_CLR, 1 << 4);
    busWrite(A_STOP_CLR, 1 << 4);
    @(negedge clk); srcPeriph = 1'b1;
    repeat (20) @(negedge clk);
    srcPeriph = 1'b0;
    busRead(chAddr(4, 2), rd);    check("R7 disabled hold", rd, 0);

    // R8 counter and compare access
    busWrite(chAddr(5, 2), 16'hBEEF);
    busRead(chAddr(5, 2), rd);    check("R8 counter", rd, 16'hBEEF);
    busWrite(chAddr(5, 1), 16'h0123);
    busRead(chAddr(5, 1), rd);    check("R8 compare", rd, 16'h0123);

    // R9 directed compare match
    tSrc[1] = 1; tPre[1] = 0; tCmp[1] = 3; tStart[1] = 0;
    runGroup(1 << 1, 10, 100);
    // R10 free-running wrap from a preload
    tSrc[6] = 4; tPre[6] = 0; tCmp[6] = 16'hFFFF; tStart[6] = 16'hFFFE;
    runGroup(1 << 6, 3, 100);
    // R6 prescale 16, 1024 and clamped value 6
    tSrc[0] = 2; tPre[0] = 2; tCmp[0] = 16'hFFFF; tStart[0] = 0;
    runGroup(1 << 0, 100, 100);
    tPre[0] = 5; runGroup(1 << 0, 2100, 100);
    tPre[0] = 6; runGroup(1 << 0, 2100, 100);
    // R5 no source selected, then real-time only under random pulses
    tSrc[3] = 0; tPre[3] = 0; tCmp[3] = 16'hFFFF; tStart[3] = 0;
    runGroup(1 << 3, 50, 100);
    tSrc[3] = 2; runGroup(1 << 3, 200, 50);
    tSrc[3] = 5; tCmp[3] = 7; runGroup(1 << 3, 200, 30);
    // R11 two channels together
    tSrc[1] = 1; tPre[1] = 1; tCmp[1] = 5;  tStart[1] = 0;
    tSrc[7] = 4; tPre[7] = 0; tCmp[7] = 9;  tStart[7] = 0;
    runGroup((1 << 1) | (1 << 7), 300, 60);

    // random configurations
    for (int k = 0; k < 8; k++) begin
      int c = int'($urandom % NCH);
      int sel = int'($urandom % 4);
      tSrc[c]   = (sel == 3) ? 0 : (1 << sel);
      tPre[c]   = int'($urandom % 3);
      tCmp[c]   = (($urandom % 4) == 0) ? 16'hFFFF : int'($urandom % 40);
      tStart[c] = 0;
      runGroup(1 << c, 200 + int'($urandom % 400), 20 + int'($urandom % 80));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule